// File: doc/BRIEF.md
# SMBus Thermal Sensor Register Slave

This block is the bus-facing register side of an on-chip temperature sensor. It listens on the two wires of an SMBus segment (clock and data, each seen as a logic level, with the data line pulled low through `sda_drive_low` in the open-drain manner). It holds the last accepted temperature reading, a status byte, a configuration byte and two limit registers. A host selects a register by writing a one-byte pointer. It can then write a data byte, read a byte back after a repeated start, or read with a bare Receive Byte transfer at the current pointer.

Temperature samples arrive as a valid/ready stream. A sample is taken only in a cycle where `temp_valid` and `temp_ready` are both high. When the configuration puts the sensor in standby, `temp_ready` drops at once. Samples offered then are not taken, and the producer may hold or drop them. Each accepted sample is compared against the limits. A crossing latches an alarm flag and pulls `alert_n` low. The host can find the source through the alert-response address. The device answers that query with its own 7-bit address and then lets the alert line go. The device address comes from two strap inputs sampled only while reset is asserted.

Top module: `thermal_smb_slave`

## Requirements
- R1: After reset, `alert_n` is 1, `sda_drive_low` is 0, `temp_ready` is 1, the configuration register reads 0x00, the status register reads 0x80, and the high and low limits read the values of the parameters `HI_RST` and `LO_RST`.
- R2: The device address is {`ADDR_BASE`[6:3], strap code, `strap_a`}. The 2-bit strap code is taken from `strap_b` (00 = tied low, 01 = tied high, 10 = left open, 11 treated as 10). It is captured only while `rst_n` is low, and later strap changes have no effect on which address is acknowledged.
- R3: A write to the device address carries a pointer byte and an optional data byte, and each byte is acknowledged by holding data low through the ninth clock. The pointer map is 0x00 temperature (read-only), 0x01 status (read-only), 0x02 configuration, 0x03 high limit, 0x04 low limit. Writes to read-only or unmapped pointers change nothing, and an unmapped pointer reads 0x00.
- R4: A read at the device address, either after a pointer write and repeated start or as a bare Receive Byte, returns the register at the current pointer, MSB first. Data changes only while the clock is low, and the master's not-acknowledge ends the transfer.
- R5: A transfer whose first byte matches neither the device address nor an accepted alert query is not acknowledged. The rest of it, up to the next start, is ignored and changes no register.
- R6: Only configuration bit 6 (standby) is stored, and the other bits always read 0. With bit 6 set, `temp_ready` is 0 and status bit 7 (busy) reads 0. With bit 6 clear, both read 1.
- R7: A sample is accepted only when `temp_valid` and `temp_ready` are both 1, and its value then reads back at pointer 0x00.
- R8: An accepted sample above the high limit sets status bit 4, one below the low limit sets bit 3, and one flagged by `temp_diode_open` sets bit 2 (unsigned compares). These bits stay set until a status read, which returns them and then clears them.
- R9: `alert_n` is 0 while any alarm bit is set and no alert query has been served since the last new alarm event. A new alarm event pulls it low again.
- R10: A read at address 0x0C is acknowledged only while `alert_n` is 0 and returns {device address, 1}. Once the master's acknowledge bit has been clocked, `alert_n` returns to 1 while the alarm bits stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset; straps are captured while it is low |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level as seen on the wire |
| sda_drive_low | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_a | input | 1 | Two-level address strap |
| strap_b | input | 2 | Three-level address strap as a code |
| temp_data | input | 8 | Temperature sample |
| temp_diode_open | input | 1 | Sample was taken with the sensing diode open |
| temp_valid | input | 1 | Sample offered |
| temp_ready | output | 1 | Sample can be taken (not in standby) |
| alert_n | output | 1 | Active-low alert line |

## Verification
The bench builds the block with `ADDR_BASE` = 0x48, `HI_RST` = 0x55 and `LO_RST` = 0x05, with the straps at `strap_a` = 1 and `strap_b` = open. The device therefore sits at 0x4D, away from the alert-response address 0x0C, and the non-zero reset limits make the reset values visible. A low limit of 0x05 leaves room below it for an under-range sample, and the high limit can be rewritten so that one sample can fall on either side of it. The strap change after reset shows whether the address can move from 0x4D to 0x48.

// File: rtl/tsn_pkg.sv
package tsn_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_WCMD, ST_WDATA, ST_TX, ST_TACK, ST_IGNORE
  } bus_st_e;

  localparam logic [7:0] PTR_TEMP = 8'h00;
  localparam logic [7:0] PTR_STAT = 8'h01;
  localparam logic [7:0] PTR_CFG  = 8'h02;
  localparam logic [7:0] PTR_HI   = 8'h03;
  localparam logic [7:0] PTR_LO   = 8'h04;

  localparam int CFG_STANDBY = 6;

  localparam int ALM_HI   = 0;
  localparam int ALM_LO   = 1;
  localparam int ALM_OPEN = 2;
  localparam int ALM_N    = 3;
endpackage

// File: rtl/tsn_line_sampler.sv
module tsn_line_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_bit
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  assign scl_rise  = !scl_q && scl_in;
  assign scl_fall  = scl_q && !scl_in;
  assign start_det = scl_q && scl_in && sda_q && !sda_in;
  assign stop_det  = scl_q && scl_in && !sda_q && sda_in;
  assign sda_bit   = sda_in;
endmodule

// File: rtl/tsn_bus_fsm.sv
module tsn_bus_fsm
  import tsn_pkg::*;
#(
  parameter logic [6:0] ARA_ADDR = 7'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_bit,
  input  logic [6:0]        dev_addr,
  input  logic              alert_active,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_drive_low,
  output logic              ptr_wr,
  output logic              data_wr,
  output logic              rd_req,
  output logic              ara_ack,
  output logic [BYTE_W-1:0] rx_byte
);
  bus_st_e              st, after_ack;
  logic                 tx_ara;
  logic [BYTE_W-1:0]    shreg;
  logic [BIT_CNT_W-1:0] cnt;
  logic                 rx_state, rx_done;
  logic                 hit_wr, hit_rd, hit_ara;

  assign rx_state = (st == ST_ADDR) || (st == ST_WCMD) || (st == ST_WDATA);
  assign rx_done  = rx_state && scl_fall && (cnt == BIT_CNT_W'(BYTE_W));
  assign hit_wr   = (shreg[7:1] == dev_addr) && !shreg[0];
  assign hit_rd   = (shreg[7:1] == dev_addr) && shreg[0];
  assign hit_ara  = (shreg[7:1] == ARA_ADDR) && shreg[0] && alert_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      after_ack <= ST_IDLE;
      tx_ara    <= 1'b0;
      shreg     <= '0;
      cnt       <= '0;
    end else if (start_det) begin
      st  <= ST_ADDR;
      cnt <= '0;
    end else if (stop_det) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_ADDR, ST_WCMD, ST_WDATA: begin
          if (scl_rise && cnt != BIT_CNT_W'(BYTE_W)) begin
            shreg <= {shreg[BYTE_W-2:0], sda_bit};
            cnt   <= cnt + 1'b1;
          end else if (rx_done) begin
            cnt <= '0;
            if (st == ST_WCMD) begin
              st        <= ST_ACK;
              after_ack <= ST_WDATA;
            end else if (st == ST_WDATA) begin
              st        <= ST_ACK;
              after_ack <= ST_IGNORE;
            end else if (hit_wr) begin
              st        <= ST_ACK;
              after_ack <= ST_WCMD;
            end else if (hit_rd || hit_ara) begin
              st        <= ST_ACK;
              after_ack <= ST_TX;
              tx_ara    <= !hit_rd;
            end else begin
              st <= ST_IGNORE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            st  <= after_ack;
            cnt <= '0;
            if (after_ack == ST_TX)
              shreg <= tx_ara ? {dev_addr, 1'b1} : rd_data;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == BIT_CNT_W'(BYTE_W - 1)) begin
              st <= ST_TACK;
            end else begin
              shreg <= {shreg[BYTE_W-2:0], 1'b0};
              cnt   <= cnt + 1'b1;
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) st <= ST_IGNORE;
        end
        default: ;
      endcase
    end
  end

  assign ptr_wr        = (st == ST_WCMD) && rx_done;
  assign data_wr       = (st == ST_WDATA) && rx_done;
  assign rd_req        = (st == ST_ACK) && scl_fall && (after_ack == ST_TX) && !tx_ara && !start_det && !stop_det;
  assign ara_ack       = (st == ST_TACK) && scl_rise && tx_ara && !start_det && !stop_det;
  assign sda_drive_low = (st == ST_ACK) || ((st == ST_TX) && !shreg[BYTE_W-1]);
  assign rx_byte       = shreg;
endmodule

// File: rtl/tsn_reg_file.sv
module tsn_reg_file
  import tsn_pkg::*;
#(
  parameter logic [7:0] HI_RST = 8'h50,
  parameter logic [7:0] LO_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr,
  input  logic              data_wr,
  input  logic              rd_req,
  input  logic              ara_ack,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [BYTE_W-1:0] temp_data,
  input  logic              temp_diode_open,
  input  logic              temp_valid,
  output logic              temp_ready,
  output logic [BYTE_W-1:0] rd_data,
  output logic              alert_n,
  output logic [ALM_N-1:0]  alarm_flags,
  output logic [BYTE_W-1:0] temp_value
);
  logic [BYTE_W-1:0] ptr_q, temp_q, hi_q, lo_q;
  logic              standby_q, served_q;
  logic              accept, stat_rd;
  logic [ALM_N-1:0]  alm_set;

  assign accept  = temp_valid && temp_ready;
  assign stat_rd = rd_req && (ptr_q == PTR_STAT);

  always_comb begin
    alm_set           = '0;
    alm_set[ALM_HI]   = accept && (temp_data > hi_q);
    alm_set[ALM_LO]   = accept && (temp_data < lo_q);
    alm_set[ALM_OPEN] = accept && temp_diode_open;
  end

  for (genvar i = 0; i < ALM_N; i++) begin : g_alarm
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (alm_set[i]) flag_q <= 1'b1;
      else if (stat_rd)    flag_q <= 1'b0;
    end
    assign alarm_flags[i] = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= PTR_TEMP;
      temp_q    <= '0;
      hi_q      <= HI_RST;
      lo_q      <= LO_RST;
      standby_q <= 1'b0;
      served_q  <= 1'b0;
    end else begin
      if (accept) temp_q <= temp_data;
      if (ptr_wr) ptr_q <= wr_byte;
      if (data_wr) begin
        case (ptr_q)
          PTR_CFG: standby_q <= wr_byte[CFG_STANDBY];
          PTR_HI:  hi_q      <= wr_byte;
          PTR_LO:  lo_q      <= wr_byte;
          default: ;
        endcase
      end
      if (|alm_set)     served_q <= 1'b0;
      else if (ara_ack) served_q <= 1'b1;
    end
  end

  always_comb begin
    case (ptr_q)
      PTR_TEMP: rd_data = temp_q;
      PTR_STAT: rd_data = {!standby_q, 2'b00, alarm_flags[ALM_HI], alarm_flags[ALM_LO],
                           alarm_flags[ALM_OPEN], 2'b00};
      PTR_CFG:  rd_data = 8'(standby_q) << CFG_STANDBY;
      PTR_HI:   rd_data = hi_q;
      PTR_LO:   rd_data = lo_q;
      default:  rd_data = '0;
    endcase
  end

  assign temp_ready = !standby_q;
  assign alert_n    = !((|alarm_flags) && !served_q);
  assign temp_value = temp_q;
endmodule

// File: rtl/thermal_smb_slave.sv
module thermal_smb_slave
  import tsn_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'h18,
  parameter logic [6:0] ARA_ADDR  = 7'h0C,
  parameter logic [7:0] HI_RST    = 8'h50,
  parameter logic [7:0] LO_RST    = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_drive_low,
  input  logic       strap_a,
  input  logic [1:0] strap_b,
  input  logic [7:0] temp_data,
  input  logic       temp_diode_open,
  input  logic       temp_valid,
  output logic       temp_ready,
  output logic       alert_n
);
  logic              scl_rise, scl_fall, start_det, stop_det, sda_bit;
  logic              ptr_wr, data_wr, rd_req, ara_ack;
  logic [BYTE_W-1:0] rx_byte, rd_data, temp_w;
  logic [ALM_N-1:0]  alarm_w;
  logic [6:0]        dev_addr;
  logic [1:0]        strap_code;

  assign strap_code = (strap_b == 2'b11) ? 2'b10 : strap_b;

  always_ff @(posedge clk) begin
    if (!rst_n) dev_addr <= {ADDR_BASE[6:3], strap_code, strap_a};
  end

  tsn_line_sampler u_lines (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_bit(sda_bit)
  );

  tsn_bus_fsm #(.ARA_ADDR(ARA_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit),
    .dev_addr(dev_addr), .alert_active(!alert_n), .rd_data(rd_data),
    .sda_drive_low(sda_drive_low), .ptr_wr(ptr_wr), .data_wr(data_wr),
    .rd_req(rd_req), .ara_ack(ara_ack), .rx_byte(rx_byte)
  );

  tsn_reg_file #(.HI_RST(HI_RST), .LO_RST(LO_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .data_wr(data_wr),
    .rd_req(rd_req), .ara_ack(ara_ack), .wr_byte(rx_byte),
    .temp_data(temp_data), .temp_diode_open(temp_diode_open),
    .temp_valid(temp_valid), .temp_ready(temp_ready), .rd_data(rd_data),
    .alert_n(alert_n), .alarm_flags(alarm_w), .temp_value(temp_w)
  );
endmodule

// File: rtl/tsn_checker.sv
module tsn_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_drive_low,
  input logic       temp_ready,
  input logic       alert_n,
  input logic [2:0] alarm_w,
  input logic [7:0] temp_w,
  input logic       rd_req,
  input logic       ara_ack,
  input logic [6:0] dev_addr
);
  // R9
  alert_needs_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_n |-> (alarm_w != 3'b000));

  // R8
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(alarm_w) & ~alarm_w) != 3'b000) |-> $past(rd_req));

  // R7
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_ready |=> $stable(temp_w));

  // R10
  alert_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_n) |-> ($past(ara_ack) || (alarm_w == 3'b000)));

  // R4
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_in);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(dev_addr));
endmodule

bind thermal_smb_slave tsn_checker chk_i (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_drive_low(sda_drive_low),
  .temp_ready(temp_ready), .alert_n(alert_n), .alarm_w(alarm_w),
  .temp_w(temp_w), .rd_req(rd_req), .ara_ack(ara_ack), .dev_addr(dev_addr)
);

// File: tb/thermal_smb_slave_tb_top.sv
module thermal_smb_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam logic [6:0] DEV = 7'h4D;
  localparam logic [6:0] ARA = 7'h0C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic       sda_drive_low, temp_ready, alert_n;
  logic       strap_a = 1'b1;
  logic [1:0] strap_b = 2'b10;
  logic [7:0] temp_data = 8'h00;
  logic       temp_diode_open = 1'b0, temp_valid = 1'b0;
  logic       sda_line;
  int vectors = 0;
  int fails = 0;

  assign sda_line = m_sda & ~sda_drive_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_smb_slave #(.ADDR_BASE(7'h48), .HI_RST(8'h55), .LO_RST(8'h05)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_drive_low(sda_drive_low), .strap_a(strap_a), .strap_b(strap_b),
    .temp_data(temp_data), .temp_diode_open(temp_diode_open),
    .temp_valid(temp_valid), .temp_ready(temp_ready), .alert_n(alert_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(HALF);
    m_scl = 1'b1; tick(HALF);
    m_sda = 1'b0; tick(HALF);
    m_scl = 1'b0; tick(1);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(HALF);
    m_scl = 1'b1; tick(HALF);
    m_sda = 1'b1; tick(HALF);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; tick(HALF);
    m_scl = 1'b1; tick(HALF);
    m_scl = 1'b0; tick(1);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; tick(HALF);
    m_scl = 1'b1; tick(HALF/2);
    b = sda_line; tick(HALF - HALF/2);
    m_scl = 1'b0; tick(1);
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic read_byte(output logic [7:0] d, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(nack);
  endtask

  task automatic reg_write(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                           output logic ok);
    logic k1, k2, k3;
    bus_start();
    write_byte({a, 1'b0}, k1);
    write_byte(p, k2);
    write_byte(d, k3);
    bus_stop();
    ok = k1 & k2 & k3;
  endtask

  task automatic reg_read(input logic [6:0] a, input logic [7:0] p, output logic [7:0] d,
                          output logic ok);
    logic k1, k2, k3;
    bus_start();
    write_byte({a, 1'b0}, k1);
    write_byte(p, k2);
    bus_start();
    write_byte({a, 1'b1}, k3);
    read_byte(d, 1'b1);
    bus_stop();
    ok = k1 & k2 & k3;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic k1, k2;
    bus_start();
    write_byte({DEV, 1'b0}, k1);
    write_byte(p, k2);
    bus_stop();
    check("R3 pointer write ack", {7'b0, k1 & k2}, 8'h01);
  endtask

  task automatic recv_txn(input logic [6:0] a, output logic [7:0] d, output logic ok);
    bus_start();
    write_byte({a, 1'b1}, ok);
    read_byte(d, 1'b1);
    bus_stop();
  endtask

  task automatic push(input logic [7:0] d, input logic open);
    temp_data = d; temp_diode_open = open; temp_valid = 1'b1;
    tick(1);
    temp_valid = 1'b0; temp_diode_open = 1'b0;
    tick(2);
  endtask

  task automatic expect_reg(input string tag, input logic [7:0] p, input logic [7:0] exp);
    logic [7:0] d;
    logic ok;
    reg_read(DEV, p, d, ok);
    check({tag, " ack"}, {7'b0, ok}, 8'h01);
    check(tag, d, exp);
  endtask

  task automatic t_reset();
    check("R1 alert_n", {7'b0, alert_n}, 8'h01);
    check("R1 sda released", {7'b0, sda_drive_low}, 8'h00);
    check("R1 temp_ready", {7'b0, temp_ready}, 8'h01);
    expect_reg("R1 config", 8'h02, 8'h00);
    expect_reg("R1 status", 8'h01, 8'h80);
    expect_reg("R1 high limit", 8'h03, 8'h55);
    expect_reg("R1 low limit", 8'h04, 8'h05);
  endtask

  task automatic t_sample();
    push(8'h30, 1'b0);
    expect_reg("R7 temp readback", 8'h00, 8'h30);
    expect_reg("R8 no alarm in range", 8'h01, 8'h80);
    check("R9 no alert in range", {7'b0, alert_n}, 8'h01);
  endtask

  task automatic t_write();
    logic ok;
    reg_write(DEV, 8'h03, 8'h60, ok);
    check("R3 write ack", {7'b0, ok}, 8'h01);
    expect_reg("R3 high limit written", 8'h03, 8'h60);
    reg_write(DEV, 8'h00, 8'hAA, ok);
    expect_reg("R3 read-only temp unchanged", 8'h00, 8'h30);
    expect_reg("R3 unmapped reads zero", 8'h07, 8'h00);
  endtask

  task automatic t_receive();
    logic [7:0] d;
    logic ok;
    set_ptr(8'h03);
    recv_txn(DEV, d, ok);
    check("R4 receive byte ack", {7'b0, ok}, 8'h01);
    check("R4 receive byte data", d, 8'h60);
    recv_txn(DEV, d, ok);
    check("R4 receive byte repeat", d, 8'h60);
  endtask

  task automatic t_standby();
    logic ok;
    reg_write(DEV, 8'h02, 8'hFF, ok);
    expect_reg("R6 reserved bits read zero", 8'h02, 8'h40);
    check("R6 ready low in standby", {7'b0, temp_ready}, 8'h00);
    expect_reg("R6 busy clear in standby", 8'h01, 8'h00);
    push(8'h70, 1'b0);
    expect_reg("R7 sample refused in standby", 8'h00, 8'h30);
    check("R7 no alert from refused sample", {7'b0, alert_n}, 8'h01);
    reg_write(DEV, 8'h02, 8'h00, ok);
    check("R6 ready back after resume", {7'b0, temp_ready}, 8'h01);
    expect_reg("R6 busy after resume", 8'h01, 8'h80);
  endtask

  task automatic t_mismatch();
    logic ok;
    bus_start();
    write_byte({DEV ^ 7'h01, 1'b0}, ok);
    check("R5 wrong address not acked", {7'b0, ok}, 8'h00);
    write_byte(8'h03, ok);
    check("R5 later byte not acked", {7'b0, ok}, 8'h00);
    write_byte(8'h11, ok);
    bus_stop();
    expect_reg("R5 register untouched", 8'h03, 8'h60);
  endtask

  task automatic t_alarm();
    push(8'h70, 1'b0);
    check("R9 alert on high crossing", {7'b0, alert_n}, 8'h00);
    expect_reg("R8 high alarm reported", 8'h01, 8'h90);
    expect_reg("R8 alarm cleared by read", 8'h01, 8'h80);
    check("R9 alert released after clear", {7'b0, alert_n}, 8'h01);
    push(8'h02, 1'b1);
    check("R9 alert on low and open", {7'b0, alert_n}, 8'h00);
  endtask

  task automatic t_ara();
    logic [7:0] d;
    logic ok;
    recv_txn(ARA, d, ok);
    check("R10 alert query acked", {7'b0, ok}, 8'h01);
    check("R10 alert query data", d, {DEV, 1'b1});
    check("R10 alert released", {7'b0, alert_n}, 8'h01);
    expect_reg("R10 alarms kept after query", 8'h01, 8'h8C);
    recv_txn(ARA, d, ok);
    check("R10 query ignored when quiet", {7'b0, ok}, 8'h00);
    push(8'h70, 1'b0);
    recv_txn(ARA, d, ok);
    check("R10 second query acked", {7'b0, ok}, 8'h01);
    push(8'h71, 1'b0);
    check("R9 new event rearms alert", {7'b0, alert_n}, 8'h00);
    expect_reg("R8 high alarm after rearm", 8'h01, 8'h90);
  endtask

  task automatic t_strap();
    logic [7:0] d;
    logic ok;
    strap_a = 1'b0;
    strap_b = 2'b00;
    tick(4);
    reg_read(7'h48, 8'h03, d, ok);
    check("R2 new strap address ignored", {7'b0, ok}, 8'h00);
    reg_read(DEV, 8'h03, d, ok);
    check("R2 latched address still acked", {7'b0, ok}, 8'h01);
    check("R2 latched address data", d, 8'h60);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_sample();
    t_write();
    t_receive();
    t_standby();
    t_mismatch();
    t_alarm();
    t_ara();
    t_strap();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule